// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block caches page translations for a processor. On every lookup it compares a virtual page number and the current process number against all stored entries at once. In the same cycle it returns the physical address built from the stored frame number and the untouched page offset. If no entry matches, a miss is signalled so that software can refill the buffer. If the key matches but the stored page-table copy is marked not valid, a page fault is signalled instead of a hit. The block walks no page table itself.

Software fills entries through a write port. The slot is either named explicitly or drawn from a free-running pseudo-random generator that never lands in the low slots kept for the operating system. A write whose key already lives in the buffer replaces that entry, so a key is never held twice. Because each entry carries its process number, translations survive a context switch. A flush of one process number retires a recycled ID, and a full flush empties the buffer. The only field the block changes by itself is the dirty bit, which it sets when a store hits a clean page.

Top module: `xlat_tlb`

## Requirements
- R1: When a lookup matches a live entry whose page-table valid copy is 1, `lk_hit` is 1 and `lk_paddr` is the entry's 20-bit frame number in bits 31:12 followed by the lookup's own offset in bits 11:0, in the same cycle.
- R2: A match needs both the virtual page number (bits 31:12 of `lk_vaddr`) and `lk_pid` to equal the stored values. The same page under another process number does not match.
- R3: A requested lookup that matches no live entry raises `lk_miss` alone. During any request, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is 1.
- R4: A lookup that matches a live entry whose page-table valid copy is 0 raises `lk_fault`, not `lk_hit`, and `lk_paddr` is 0.
- R5: A store lookup (`lk_store`=1) that hits a clean entry sets that entry's dirty bit at the next clock edge. `lk_dirty` reports the stored bit, and a load lookup never changes it.
- R6: A random fill (`fill_rand`=1) never writes one of the 8 reserved slots 0 to 7. Entries placed there by explicit fills stay intact.
- R7: A fill whose page and process number equal those of a live entry overwrites that entry, whatever slot or mode was requested. No second copy is created.
- R8: `flush_all` retires every entry at the next edge, so that all later lookups miss. A fill presented in the same cycle as any flush is discarded.
- R9: `flush_pid_req` retires only the entries whose process number equals `flush_pid`. Other entries keep hitting.
- R10: After reset, every slot is empty and any lookup misses.
- R11: While `lk_req` is 0, `lk_hit`, `lk_miss` and `lk_fault` are all 0, and the lookup changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 6 | Process number of the requester |
| lk_store | input | 1 | Access type: 1 store, 0 load |
| lk_hit | output | 1 | Valid translation found |
| lk_miss | output | 1 | No entry matched, refill trap |
| lk_fault | output | 1 | Entry matched but page not valid |
| lk_paddr | output | 32 | Physical address, 0 unless hit |
| lk_prot | output | 3 | Protection bits of the matched entry |
| lk_dirty | output | 1 | Dirty bit of the matched entry |
| fill_req | input | 1 | Write an entry |
| fill_rand | input | 1 | 1 picks a random non-reserved slot, 0 uses fill_slot |
| fill_slot | input | 6 | Explicit slot number |
| fill_vpn | input | 20 | Virtual page number to store |
| fill_pid | input | 6 | Process number to store |
| fill_valid | input | 1 | Page-table valid copy |
| fill_dirty | input | 1 | Initial dirty bit |
| fill_prot | input | 3 | Protection bits |
| fill_pfn | input | 20 | Physical frame number |
| flush_all | input | 1 | Retire every entry |
| flush_pid_req | input | 1 | Retire entries of one process |
| flush_pid | input | 6 | Process number to retire |

## Verification
The bench goes after a key that shares its page with another process. A design that ignored the process field would return the wrong frame. It refills a key that is already held through a different slot and then overwrites the old slot. A design that allocated a second copy would keep hitting after the overwrite. It fills the reserved slots and then runs many random fills. A generator that folded its range wrongly would evict a reserved entry, which then misses. It also checks that a store marks a clean page dirty only from the next cycle, that a load never does, that a fill beside a flush is dropped, and that a process flush spares other processes.

// File: rtl/xlat_pkg.sv
// Shared constants and helpers for the process-tagged translation buffer.
// Assumes slot counts between 8 and 256 (LFSR widths 3..8).
package xlat_pkg;
    localparam int XLAT_ENTRIES  = 64;
    localparam int XLAT_RESERVED = 8;
    localparam int XLAT_VA_W     = 32;
    localparam int XLAT_PA_W     = 32;
    localparam int XLAT_PAGE_W   = 12;
    localparam int XLAT_PID_W    = 6;
    localparam int XLAT_PROT_W   = 3;

    // Maximal-length feedback taps for a left-shifting Fibonacci LFSR of width w.
    function automatic logic [7:0] lfsr_taps(input int w);
        case (w)
            3:       return 8'b0000_0110;
            4:       return 8'b0000_1100;
            5:       return 8'b0001_0100;
            6:       return 8'b0011_0000;
            7:       return 8'b0110_0000;
            default: return 8'b1011_1000;
        endcase
    endfunction
endpackage

// File: rtl/xlat_rand_idx.sv
// Free-running pseudo-random slot generator. A maximal LFSR of log2(ENTRIES)
// bits steps every cycle; values below RESERVED are shifted up by RESERVED so
// the result always lies in [RESERVED, ENTRIES-1].
// Assumes RESERVED <= ENTRIES/2 and ENTRIES a power of two.
module xlat_rand_idx import xlat_pkg::*; #(
    parameter int ENTRIES  = XLAT_ENTRIES,
    parameter int RESERVED = XLAT_RESERVED
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [$clog2(ENTRIES)-1:0] slot
);
    localparam int         IDX_W    = $clog2(ENTRIES);
    localparam logic [7:0] TAPS_ALL = lfsr_taps(IDX_W);
    localparam logic [IDX_W-1:0] TAPS = TAPS_ALL[IDX_W-1:0];
    localparam logic [IDX_W-1:0] RES  = IDX_W'(RESERVED);

    logic [IDX_W-1:0] state_q;

    // Step the LFSR every cycle from a non-zero seed.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDX_W'(1);
        else        state_q <= {state_q[IDX_W-2:0], ^(state_q & TAPS)};
    end

    // Fold the reserved low range into the upper slots.
    always_comb begin
        slot = (state_q < RES) ? state_q + RES : state_q;
    end

    // R6: the generator never offers a reserved slot.
    assert_slot_outside_reserved_R6: assert property (
        @(posedge clk) disable iff (!rst_n) slot >= RES
    );
endmodule

// File: rtl/xlat_onehot_enc.sv
// Converts a one-hot (or empty) match vector into a slot number and an
// any-bit. Assumes at most one bit is set; several set bits give their OR.
module xlat_onehot_enc #(
    parameter int N = 64
) (
    input  logic [N-1:0]         onehot,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int IDX_W = $clog2(N);

    // OR together the numbers of the set bits.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
        end
        any = |onehot;
    end
endmodule

// File: rtl/xlat_entry_array.sv
// Storage and parallel comparators for all translation slots. Each slot holds
// a live flag, page number, process number, page-table valid copy, dirty bit,
// protection bits and frame number. Two comparator banks run side by side:
// one for the lookup key and one for the fill key (duplicate detection).
// Assumes fill_en is already cleared by the caller when any flush is active.
module xlat_entry_array #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PID_W   = 6,
    parameter int PFN_W   = 20,
    parameter int PROT_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [VPN_W-1:0]           look_vpn,
    input  logic [PID_W-1:0]           look_pid,
    input  logic                       fill_en,
    input  logic [$clog2(ENTRIES)-1:0] fill_slot,
    input  logic [VPN_W-1:0]           fill_vpn,
    input  logic [PID_W-1:0]           fill_pid,
    input  logic                       fill_valid,
    input  logic                       fill_dirty,
    input  logic [PROT_W-1:0]          fill_prot,
    input  logic [PFN_W-1:0]           fill_pfn,
    input  logic                       kill_all,
    input  logic                       kill_pid_en,
    input  logic [PID_W-1:0]           kill_pid,
    input  logic [ENTRIES-1:0]         dirty_set,
    output logic [ENTRIES-1:0]         look_match,
    output logic [ENTRIES-1:0]         fill_match,
    output logic [ENTRIES-1:0]         ent_valid,
    output logic [ENTRIES-1:0]         ent_dirty,
    output logic [PROT_W-1:0]          ent_prot [ENTRIES],
    output logic [PFN_W-1:0]           ent_pfn  [ENTRIES]
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] live_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PID_W-1:0]   pid_q [ENTRIES];
    logic [ENTRIES-1:0] wr_sel;
    logic [ENTRIES-1:0] kill;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        // Per-slot decode of write target, flush hit and key comparisons.
        assign wr_sel[e]     = fill_en && (fill_slot == IDX_W'(e));
        assign kill[e]       = kill_all || (kill_pid_en && pid_q[e] == kill_pid);
        assign look_match[e] = live_q[e] && vpn_q[e] == look_vpn && pid_q[e] == look_pid;
        assign fill_match[e] = live_q[e] && vpn_q[e] == fill_vpn && pid_q[e] == fill_pid;

        // R5: a store hit on a clean slot leaves it dirty one cycle later.
        assert_store_marks_dirty_R5: assert property (
            @(posedge clk) disable iff (!rst_n)
            dirty_set[e] && !wr_sel[e] |=> ent_dirty[e]
        );
    end

    // Occupancy: flushes retire slots, fills make them live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (kill[e])        live_q[e] <= 1'b0;
                else if (wr_sel[e]) live_q[e] <= 1'b1;
            end
        end
    end

    // Payload: fills load all fields; store hits set the dirty bit in place.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (wr_sel[e]) begin
                vpn_q[e]     <= fill_vpn;
                pid_q[e]     <= fill_pid;
                ent_valid[e] <= fill_valid;
                ent_dirty[e] <= fill_dirty;
                ent_prot[e]  <= fill_prot;
                ent_pfn[e]   <= fill_pfn;
            end else if (dirty_set[e]) begin
                ent_dirty[e] <= 1'b1;
            end
        end
    end

    // R8: a full flush leaves no live slot.
    assert_flush_empties_R8: assert property (
        @(posedge clk) disable iff (!rst_n) kill_all |=> live_q == '0
    );

    // R7: duplicate-key replacement keeps every key in at most one slot.
    assert_key_unique_R7: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(look_match)
    );
endmodule

// File: rtl/xlat_tlb.sv
// Process-tagged fully associative translation buffer, top level.
// Lookup is combinational against registered entries: the result is valid in
// the cycle of the request. Fills and flushes take effect at the next edge.
// A fill whose key is already live is steered to the holding slot; otherwise
// it goes to fill_slot or to a random slot above the reserved range. Any
// flush in the same cycle discards the fill. Assumes a power-of-two slot count.
module xlat_tlb import xlat_pkg::*; #(
    parameter int ENTRIES  = XLAT_ENTRIES,
    parameter int RESERVED = XLAT_RESERVED,
    parameter int VA_W     = XLAT_VA_W,
    parameter int PA_W     = XLAT_PA_W,
    parameter int PAGE_W   = XLAT_PAGE_W,
    parameter int PID_W    = XLAT_PID_W,
    parameter int PROT_W   = XLAT_PROT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_req,
    input  logic [VA_W-1:0]            lk_vaddr,
    input  logic [PID_W-1:0]           lk_pid,
    input  logic                       lk_store,
    output logic                       lk_hit,
    output logic                       lk_miss,
    output logic                       lk_fault,
    output logic [PA_W-1:0]            lk_paddr,
    output logic [PROT_W-1:0]          lk_prot,
    output logic                       lk_dirty,
    input  logic                       fill_req,
    input  logic                       fill_rand,
    input  logic [$clog2(ENTRIES)-1:0] fill_slot,
    input  logic [VA_W-PAGE_W-1:0]     fill_vpn,
    input  logic [PID_W-1:0]           fill_pid,
    input  logic                       fill_valid,
    input  logic                       fill_dirty,
    input  logic [PROT_W-1:0]          fill_prot,
    input  logic [PA_W-PAGE_W-1:0]     fill_pfn,
    input  logic                       flush_all,
    input  logic                       flush_pid_req,
    input  logic [PID_W-1:0]           flush_pid
);
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PFN_W = PA_W - PAGE_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] look_match, fill_match, dirty_set;
    logic [ENTRIES-1:0] ent_valid, ent_dirty;
    logic [PROT_W-1:0]  ent_prot [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    logic [IDX_W-1:0]   hit_idx, dup_idx, rand_slot, tgt_slot;
    logic               look_any, dup_any, fill_en;
    logic               sel_valid, sel_dirty;
    logic [PROT_W-1:0]  sel_prot;
    logic [PFN_W-1:0]   sel_pfn;

    xlat_rand_idx #(.ENTRIES(ENTRIES), .RESERVED(RESERVED)) u_rand (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (rand_slot)
    );

    xlat_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W),
        .PFN_W(PFN_W), .PROT_W(PROT_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_vpn   (lk_vaddr[VA_W-1:PAGE_W]),
        .look_pid   (lk_pid),
        .fill_en    (fill_en),
        .fill_slot  (tgt_slot),
        .fill_vpn   (fill_vpn),
        .fill_pid   (fill_pid),
        .fill_valid (fill_valid),
        .fill_dirty (fill_dirty),
        .fill_prot  (fill_prot),
        .fill_pfn   (fill_pfn),
        .kill_all   (flush_all),
        .kill_pid_en(flush_pid_req),
        .kill_pid   (flush_pid),
        .dirty_set  (dirty_set),
        .look_match (look_match),
        .fill_match (fill_match),
        .ent_valid  (ent_valid),
        .ent_dirty  (ent_dirty),
        .ent_prot   (ent_prot),
        .ent_pfn    (ent_pfn)
    );

    xlat_onehot_enc #(.N(ENTRIES)) u_look_enc (
        .onehot(look_match),
        .idx   (hit_idx),
        .any   (look_any)
    );

    xlat_onehot_enc #(.N(ENTRIES)) u_dup_enc (
        .onehot(fill_match),
        .idx   (dup_idx),
        .any   (dup_any)
    );

    // Read the fields of the matched slot.
    always_comb begin
        sel_valid = ent_valid[hit_idx];
        sel_dirty = ent_dirty[hit_idx];
        sel_prot  = ent_prot[hit_idx];
        sel_pfn   = ent_pfn[hit_idx];
    end

    // Classify the lookup and form the physical address.
    always_comb begin
        lk_hit   = lk_req && look_any && sel_valid;
        lk_fault = lk_req && look_any && !sel_valid;
        lk_miss  = lk_req && !look_any;
        lk_paddr = lk_hit ? {sel_pfn, lk_vaddr[PAGE_W-1:0]} : '0;
        lk_prot  = (lk_req && look_any) ? sel_prot : '0;
        lk_dirty = lk_req && look_any && sel_dirty;
    end

    // Mark the hit slot dirty when a store touches a clean page.
    always_comb begin
        dirty_set = (lk_hit && lk_store && !sel_dirty) ? look_match : '0;
    end

    // Pick the fill target and drop the fill under any flush.
    always_comb begin
        if (dup_any)        tgt_slot = dup_idx;
        else if (fill_rand) tgt_slot = rand_slot;
        else                tgt_slot = fill_slot;
        fill_en = fill_req && !flush_all && !flush_pid_req;
    end

    // R3: a request yields exactly one outcome.
    assert_one_outcome_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        lk_req |-> $countones({lk_hit, lk_miss, lk_fault}) == 1
    );

    // R11: no outcome without a request.
    assert_quiet_when_idle_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_miss || lk_fault)
    );

    // R4: a fault never carries an address.
    assert_fault_no_addr_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_paddr == '0
    );
endmodule

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_store = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_pid = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_prot;
    logic        fill_req = 1'b0, fill_rand = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0;
    logic [5:0]  fill_slot = '0, fill_pid = '0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [2:0]  fill_prot = '0;
    logic        flush_all = 1'b0, flush_pid_req = 1'b0;
    logic [5:0]  flush_pid = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    xlat_tlb i_xlat_tlb (.*);

    localparam logic [2:0] HIT = 3'b001, MISS = 3'b010, FAULT = 3'b100;

    typedef struct packed {
        logic        is_look;
        logic [5:0]  slot;
        logic [19:0] vpn;
        logic [5:0]  pid;
        logic        ok;
        logic [19:0] pfn;
        logic [2:0]  exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd10, 20'h00012, 6'd3, 1'b1, 20'hABCDE, 3'b000},
        '{1'b0, 6'd11, 20'h00012, 6'd4, 1'b1, 20'h11111, 3'b000},
        '{1'b0, 6'd20, 20'h00777, 6'd3, 1'b0, 20'h22222, 3'b000},
        '{1'b1, 6'd0,  20'h00012, 6'd3, 1'b0, 20'hABCDE, 3'b001},
        '{1'b1, 6'd0,  20'h00012, 6'd4, 1'b0, 20'h11111, 3'b001},
        '{1'b1, 6'd0,  20'h00012, 6'd5, 1'b0, 20'h00000, 3'b010},
        '{1'b1, 6'd0,  20'h00013, 6'd3, 1'b0, 20'h00000, 3'b010},
        '{1'b1, 6'd0,  20'h00777, 6'd3, 1'b0, 20'h00000, 3'b100},
        '{1'b0, 6'd30, 20'h00012, 6'd3, 1'b1, 20'h33333, 3'b000},
        '{1'b1, 6'd0,  20'h00012, 6'd3, 1'b0, 20'h33333, 3'b001},
        '{1'b1, 6'd0,  20'h00777, 6'd4, 1'b0, 20'h00000, 3'b010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fill one entry (optionally alongside flushes); commits at the edge in between.
    task automatic wr(input logic rnd, input logic [5:0] slot, input logic [19:0] vpn,
                      input logic [5:0] pid, input logic ok, input logic dirty,
                      input logic [19:0] pfn);
        @(negedge clk);
        lk_req = 1'b0;
        fill_req = 1'b1; fill_rand = rnd; fill_slot = slot; fill_vpn = vpn;
        fill_pid = pid; fill_valid = ok; fill_dirty = dirty; fill_prot = 3'd5;
        fill_pfn = pfn;
        @(negedge clk);
        fill_req = 1'b0; flush_all = 1'b0; flush_pid_req = 1'b0;
    endtask

    // Present a lookup and let outputs settle; request stays up over the next edge.
    task automatic look(input logic [19:0] vpn, input logic [5:0] pid, input logic st,
                        input logic [11:0] off);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = {vpn, off}; lk_pid = pid; lk_store = st;
        #1;
    endtask

    task automatic flush(input logic all, input logic [5:0] pid);
        @(negedge clk);
        lk_req = 1'b0;
        flush_all = all; flush_pid_req = !all; flush_pid = pid;
        @(negedge clk);
        flush_all = 1'b0; flush_pid_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: empty after reset.
        look(20'h0, 6'd0, 1'b0, 12'h000);
        chk("R10 reset outcome", 32'({lk_fault, lk_miss, lk_hit}), 32'(MISS));

        // Table walk: R1 hit, R2/R3 miss on key mismatch, R4 fault.
        for (int i = 0; i < NV; i++) begin
            if (!VEC[i].is_look) begin
                wr(1'b0, VEC[i].slot, VEC[i].vpn, VEC[i].pid, VEC[i].ok, 1'b0, VEC[i].pfn);
            end else begin
                logic [11:0] off;
                off = 12'(12'h3C5 + i * 7);
                look(VEC[i].vpn, VEC[i].pid, 1'b0, off);
                if (VEC[i].exp == HIT) begin
                    chk("R1 outcome", 32'({lk_fault, lk_miss, lk_hit}), 32'(HIT));
                    chk("R1 paddr", lk_paddr, {VEC[i].pfn, off});
                end else if (VEC[i].exp == MISS) begin
                    chk("R2 R3 outcome", 32'({lk_fault, lk_miss, lk_hit}), 32'(MISS));
                end else begin
                    chk("R4 outcome", 32'({lk_fault, lk_miss, lk_hit}), 32'(FAULT));
                    chk("R4 paddr", lk_paddr, 32'h0);
                end
            end
        end

        // R7: slot 10 held the only copy of (0x12,3); overwrite it with another key.
        wr(1'b0, 6'd10, 20'h00055, 6'd3, 1'b1, 1'b0, 20'h44444);
        look(20'h00012, 6'd3, 1'b0, 12'h010);
        chk("R7 no second copy", 32'({lk_fault, lk_miss, lk_hit}), 32'(MISS));
        look(20'h00055, 6'd3, 1'b0, 12'h020);
        chk("R7 new key paddr", lk_paddr, 32'h44444020);

        // R5: loads keep clean, a store dirties from the next cycle.
        wr(1'b0, 6'd40, 20'h00900, 6'd2, 1'b1, 1'b0, 20'h00005);
        look(20'h00900, 6'd2, 1'b0, 12'h001);
        chk("R5 clean after fill", 32'(lk_dirty), 32'd0);
        look(20'h00900, 6'd2, 1'b0, 12'h001);
        chk("R5 load keeps clean", 32'(lk_dirty), 32'd0);
        look(20'h00900, 6'd2, 1'b1, 12'h001);
        chk("R5 store sees old bit", 32'(lk_dirty), 32'd0);
        look(20'h00900, 6'd2, 1'b0, 12'h001);
        chk("R5 dirty after store", 32'(lk_dirty), 32'd1);

        // R11: no request, no outcome.
        @(negedge clk);
        lk_req = 1'b0; lk_vaddr = 32'h00055000; lk_pid = 6'd3;
        #1;
        chk("R11 idle outcome", 32'({lk_fault, lk_miss, lk_hit}), 32'd0);

        // R9: flush process 4 only.
        flush(1'b0, 6'd4);
        look(20'h00012, 6'd4, 1'b0, 12'h0);
        chk("R9 flushed pid misses", 32'({lk_fault, lk_miss, lk_hit}), 32'(MISS));
        look(20'h00055, 6'd3, 1'b0, 12'h0);
        chk("R9 other pid hits", 32'({lk_fault, lk_miss, lk_hit}), 32'(HIT));

        // R8: full flush with a fill in the same cycle.
        @(negedge clk);
        flush_all = 1'b1;
        wr(1'b0, 6'd50, 20'h00077, 6'd1, 1'b1, 1'b0, 20'h00077);
        look(20'h00077, 6'd1, 1'b0, 12'h0);
        chk("R8 fill beside flush dropped", 32'({lk_fault, lk_miss, lk_hit}), 32'(MISS));
        look(20'h00055, 6'd3, 1'b0, 12'h0);
        chk("R8 all retired", 32'({lk_fault, lk_miss, lk_hit}), 32'(MISS));

        // R6: reserved slots survive many random fills.
        for (int s = 0; s < 8; s++)
            wr(1'b0, 6'(s), 20'(20'hA00 + s), 6'd7, 1'b1, 1'b0, 20'(20'h100 + s));
        for (int k = 0; k < 120; k++)
            wr(1'b1, 6'd0, 20'(20'hB00 + k), 6'd7, 1'b1, 1'b0, 20'(20'h200 + k));
        for (int s = 0; s < 8; s++) begin
            look(20'(20'hA00 + s), 6'd7, 1'b0, 12'h0);
            chk("R6 reserved intact", lk_paddr, {20'(20'h100 + s), 12'h0});
        end
        look(20'(20'hB00 + 119), 6'd7, 1'b0, 12'h0);
        chk("R6 last random fill", lk_paddr, {20'(20'h200 + 119), 12'h0});

        @(negedge clk);
        lk_req = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule